// File: doc/BRIEF.md
# Pipelined Decision Forest Classifier

This block scores feature vectors with an ensemble of complete binary decision trees of fixed depth. Every tree sees the same sample. At each internal node one feature is compared against a threshold to choose a child. The leaf that is reached yields a linear term: a weight times one selected feature, plus an offset. The terms from all trees are added into one wide signed score.

Traversal is split by tree level. Each level has its own registered node position and its own read of the node tables, so a new sample can enter on every clock cycle. Scores leave in arrival order after a fixed latency. The node tables are written through a one-record-per-cycle load port. Writes take effect only while no sample is entering or in flight. With the defaults the block has 4 trees of depth 3 (15 nodes each) and 8 features of 32 bits, and it gives a 34-bit score after 7 cycles.

Top module: `dfc_forest`

## Requirements
- R1: At an internal node the sample moves to the left child when the selected feature, read as signed, is strictly below the signed threshold. Otherwise, including equality, it moves to the right child.
- R2: The load address is tree × 15 + node. Nodes are numbered heap-style: node 0 is the root and the children of node n are 2n+1 (left) and 2n+2 (right). Nodes 0..6 are split records (cfg_a = threshold). Nodes 7..14 are leaf records (cfg_a = weight, cfg_b = offset). cfg_sel is the feature index in both kinds of record.
- R3: A leaf term is the low 32 bits of ((weight × feature) arithmetically shifted right by 16), plus the offset, with wrap-around in 32 bits.
- R4: The score is the exact signed sum of the per-tree leaf terms in 34 bits and never overflows, even when every term is at its 32-bit limit.
- R5: out_valid rises exactly 7 cycles (depth + log2(trees) + 2) after the cycle in which in_valid is sampled high. Scores leave in input order, and no score appears without an input.
- R6: Samples may enter on every cycle with no gap, and each one gets its own score.
- R7: A table write is dropped when in_valid is high in the same cycle or when any sample is still in the pipeline.
- R8: A table write to an address of 60 or more changes no node of any tree.
- R9: A synchronous active-high reset clears every pipeline valid bit, so out_valid is low from the cycle after reset until new samples come through. Reset leaves the node tables unchanged.
- R10: Feature f of a sample sits in in_feat bits [32f+31 : 32f]. The 3-bit cfg_sel chooses among the 8 features.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline valid bits |
| in_valid | input | 1 | A sample is present on in_feat |
| in_feat | input | 256 | Packed sample, feature f at bits [32f+31:32f] |
| cfg_we | input | 1 | Table write request |
| cfg_addr | input | 6 | Tree × 15 + node |
| cfg_sel | input | 3 | Feature index stored in the node |
| cfg_a | input | 32 | Threshold (split) or weight (leaf) |
| cfg_b | input | 32 | Offset (leaf), unused for split records |
| out_valid | output | 1 | A score is present on out_score |
| out_score | output | 34 | Signed sum of leaf terms |

## Verification
The in-design properties assume the tables are only rewritten while the pipe is empty. They also assume in_valid is a clean level that is sampled once per cycle, so that the count of samples in flight never exceeds the pipeline length. The stimulus stays within these assumptions: table writes issued while busy are expected to be dropped rather than applied, and reset is issued between cycles. Random feature values are drawn partly from the stored thresholds and their neighbours, so the equality case of the comparison is reached often. Directed leaf settings push the terms to both 32-bit limits.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
   typedef enum logic {
      REC_SPLIT = 1'b0,
      REC_LEAF  = 1'b1
   } rec_kind_e;

   function automatic int heap_first(input int level);
      return (2 ** level) - 1;
   endfunction
endpackage

// File: rtl/dfc_tree.sv
module dfc_tree
   import dfc_pkg::*;
#(
   parameter  int TREE_ID  = 0,
   parameter  int DEPTH    = 3,
   parameter  int NUM_FEAT = 8,
   parameter  int DATA_W   = 32,
   parameter  int FRAC_W   = 16,
   parameter  int ADDR_W   = 6,
   localparam int FSEL_W   = $clog2(NUM_FEAT),
   localparam int NUM_SPL  = (2 ** DEPTH) - 1,
   localparam int NUM_LEAF = 2 ** DEPTH,
   localparam int NPT      = NUM_SPL + NUM_LEAF,
   localparam int NODE_W   = $clog2(NPT),
   localparam int BASE     = TREE_ID * NPT
) (
   input  logic                                       clk,
   input  logic                                       rst,
   input  logic                                       load_en,
   input  logic                                       busy_i,
   input  logic [ADDR_W-1:0]                          cfg_addr,
   input  logic [FSEL_W-1:0]                          cfg_sel,
   input  logic [DATA_W-1:0]                          cfg_a,
   input  logic [DATA_W-1:0]                          cfg_b,
   input  logic [DEPTH:0][NUM_FEAT-1:0][DATA_W-1:0]   samp_pipe,
   output logic [DATA_W-1:0]                          leaf_o
);

   // node tables, held in flops without reset
   logic [NUM_SPL-1:0][FSEL_W-1:0]  split_sel_q;
   logic [NUM_SPL-1:0][DATA_W-1:0]  split_thr_q;
   logic [NUM_LEAF-1:0][FSEL_W-1:0] leaf_sel_q;
   logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_wgt_q;
   logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_off_q;

   // ---------------- load decode ----------------
   logic              wr_hit;
   logic [NODE_W-1:0] wr_node;
   rec_kind_e         wr_kind;
   logic [DEPTH-1:0]  wr_spl_idx;
   logic [DEPTH-1:0]  wr_leaf_idx;

   assign wr_hit      = load_en && (int'(cfg_addr) >= BASE) && (int'(cfg_addr) < BASE + NPT);
   assign wr_node     = NODE_W'(int'(cfg_addr) - BASE);
   assign wr_kind     = (wr_node >= NODE_W'(NUM_SPL)) ? REC_LEAF : REC_SPLIT;
   assign wr_spl_idx  = wr_node[DEPTH-1:0];
   assign wr_leaf_idx = DEPTH'(wr_node - NODE_W'(NUM_SPL));

   always_ff @(posedge clk) begin
      if (wr_hit) begin
         if (wr_kind == REC_SPLIT) begin
            split_sel_q[wr_spl_idx] <= cfg_sel;
            split_thr_q[wr_spl_idx] <= cfg_a;
         end else begin
            leaf_sel_q[wr_leaf_idx] <= cfg_sel;
            leaf_wgt_q[wr_leaf_idx] <= cfg_a;
            leaf_off_q[wr_leaf_idx] <= cfg_b;
         end
      end
   end

   // ---------------- level pipeline ----------------
   logic [DEPTH-1:0] cur_pos [0:DEPTH-1];
   logic [DEPTH-1:0] nxt_pos [0:DEPTH-1];
   logic [DEPTH-1:0] pos_q   [1:DEPTH];

   for (genvar l = 0; l < DEPTH; l++) begin : g_level
      logic [DEPTH-1:0]  heap_idx;
      logic [DATA_W-1:0] feat_v;
      logic              go_right;

      if (l == 0) begin : g_root
         assign cur_pos[l] = '0;
      end else begin : g_inner
         assign cur_pos[l] = pos_q[l];
      end

      assign heap_idx   = DEPTH'(heap_first(l)) + cur_pos[l];
      assign feat_v     = samp_pipe[l][split_sel_q[heap_idx]];
      assign go_right   = !($signed(feat_v) < $signed(split_thr_q[heap_idx]));
      assign nxt_pos[l] = (cur_pos[l] << 1) | DEPTH'(go_right);
   end

   always_ff @(posedge clk) begin
      for (int l = 0; l < DEPTH; l++) begin
         pos_q[l+1] <= nxt_pos[l];
      end
   end

   // ---------------- leaf term ----------------
   logic [DEPTH-1:0]          leaf_idx;
   logic [DATA_W-1:0]         leaf_feat;
   logic signed [2*DATA_W-1:0] leaf_prod;
   logic signed [2*DATA_W-1:0] leaf_scaled;
   logic [DATA_W-1:0]         leaf_d;

   assign leaf_idx    = pos_q[DEPTH];
   assign leaf_feat   = samp_pipe[DEPTH][leaf_sel_q[leaf_idx]];
   assign leaf_prod   = $signed(leaf_wgt_q[leaf_idx]) * $signed(leaf_feat);
   assign leaf_scaled = leaf_prod >>> FRAC_W;
   assign leaf_d      = leaf_scaled[DATA_W-1:0] + leaf_off_q[leaf_idx];

   always_ff @(posedge clk) begin
      leaf_o <= leaf_d;
   end

   // tables must not move while the top reports samples in flight
   AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      busy_i |=> ($stable(split_thr_q) && $stable(split_sel_q) && $stable(leaf_wgt_q)
                  && $stable(leaf_off_q) && $stable(leaf_sel_q))); // R7

endmodule

// File: rtl/dfc_sum.sv
module dfc_sum #(
   parameter  int NUM_IN = 4,
   parameter  int DATA_W = 32,
   localparam int STAGES = $clog2(NUM_IN),
   localparam int ACC_W  = DATA_W + STAGES,
   localparam int PAD_N  = 2 ** STAGES
) (
   input  logic                           clk,
   input  logic [NUM_IN-1:0][DATA_W-1:0]  leaf_i,
   output logic [ACC_W-1:0]               sum_o
);

   for (genvar s = 0; s <= STAGES; s++) begin : g_lvl
      localparam int N = PAD_N >> s;
      logic signed [ACC_W-1:0] v [0:N-1];

      if (s == 0) begin : g_in
         for (genvar i = 0; i < N; i++) begin : g_term
            if (i < NUM_IN) begin : g_used
               assign v[i] = ACC_W'($signed(leaf_i[i]));
            end else begin : g_pad
               assign v[i] = '0;
            end
         end
      end else begin : g_add
         always_ff @(posedge clk) begin
            for (int i = 0; i < N; i++) begin
               v[i] <= g_lvl[s-1].v[2*i] + g_lvl[s-1].v[2*i+1];
            end
         end
      end
   end

   assign sum_o = g_lvl[STAGES].v[0];

endmodule

// File: rtl/dfc_forest.sv
module dfc_forest #(
   parameter  int NUM_TREES  = 4,
   parameter  int TREE_DEPTH = 3,
   parameter  int NUM_FEAT   = 8,
   parameter  int DATA_W     = 32,
   parameter  int FRAC_W     = 16,
   localparam int NPT        = (2 ** (TREE_DEPTH + 1)) - 1,
   localparam int FSEL_W     = $clog2(NUM_FEAT),
   localparam int ADDR_W     = $clog2(NUM_TREES * NPT),
   localparam int SUM_STAGES = $clog2(NUM_TREES),
   localparam int ACC_W      = DATA_W + SUM_STAGES,
   localparam int LATENCY    = TREE_DEPTH + 2 + SUM_STAGES
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic [NUM_FEAT*DATA_W-1:0]    in_feat,
   input  logic                          cfg_we,
   input  logic [ADDR_W-1:0]             cfg_addr,
   input  logic [FSEL_W-1:0]             cfg_sel,
   input  logic [DATA_W-1:0]             cfg_a,
   input  logic [DATA_W-1:0]             cfg_b,
   output logic                          out_valid,
   output logic [ACC_W-1:0]              out_score
);

   // elaboration-time parameter checks
   if (TREE_DEPTH < 2) begin : g_chk_depth
      $error("dfc_forest: TREE_DEPTH must be at least 2");
   end
   if (NUM_FEAT < 2 || (2 ** FSEL_W) != NUM_FEAT) begin : g_chk_feat
      $error("dfc_forest: NUM_FEAT must be a power of two, at least 2");
   end
   if (FRAC_W < 0 || FRAC_W >= DATA_W) begin : g_chk_frac
      $error("dfc_forest: FRAC_W must lie in [0, DATA_W)");
   end
   if (NUM_TREES < 1) begin : g_chk_trees
      $error("dfc_forest: NUM_TREES must be at least 1");
   end

   logic [LATENCY-1:0]                              vld_q;
   logic [TREE_DEPTH:0][NUM_FEAT-1:0][DATA_W-1:0]   samp_q;
   logic [NUM_TREES-1:0][DATA_W-1:0]                leaf_val;
   logic                                            busy;
   logic                                            load_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else begin
         vld_q <= {vld_q[LATENCY-2:0], in_valid};
      end
   end

   // shared sample delay line, one copy per tree level
   always_ff @(posedge clk) begin
      samp_q <= {samp_q[TREE_DEPTH-1:0], in_feat};
   end

   assign busy    = in_valid | (|vld_q);
   assign load_ok = cfg_we & ~busy;

   for (genvar t = 0; t < NUM_TREES; t++) begin : g_tree
      dfc_tree #(
         .TREE_ID  (t),
         .DEPTH    (TREE_DEPTH),
         .NUM_FEAT (NUM_FEAT),
         .DATA_W   (DATA_W),
         .FRAC_W   (FRAC_W),
         .ADDR_W   (ADDR_W)
      ) i_tree (
         .clk       (clk),
         .rst       (rst),
         .load_en   (load_ok),
         .busy_i    (busy),
         .cfg_addr  (cfg_addr),
         .cfg_sel   (cfg_sel),
         .cfg_a     (cfg_a),
         .cfg_b     (cfg_b),
         .samp_pipe (samp_q),
         .leaf_o    (leaf_val[t])
      );
   end

   dfc_sum #(
      .NUM_IN (NUM_TREES),
      .DATA_W (DATA_W)
   ) i_sum (
      .clk    (clk),
      .leaf_i (leaf_val),
      .sum_o  (out_score)
   );

   assign out_valid = vld_q[LATENCY-1];

   // ---------------- checker state ----------------
   localparam int FL_W = $clog2(LATENCY + 1) + 1;
   logic [FL_W-1:0] flight_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flight_q <= '0;
      end else begin
         flight_q <= flight_q + FL_W'(in_valid) - FL_W'(out_valid);
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      $past(rst) |-> !out_valid); // R9

   AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (flight_q != '0)); // R5

   AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
      flight_q <= FL_W'(LATENCY)); // R6

endmodule

// File: tb/test_dfc_forest.sv
module test_dfc_forest;
   localparam int NT  = 4;
   localparam int D   = 3;
   localparam int NF  = 8;
   localparam int NPT = 15;
   localparam int LAT = 7;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [255:0] in_feat;
   logic         cfg_we;
   logic [5:0]   cfg_addr;
   logic [2:0]   cfg_sel;
   logic [31:0]  cfg_a;
   logic [31:0]  cfg_b;
   logic         out_valid;
   logic [33:0]  out_score;

   dfc_forest i_dfc_forest (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_feat(in_feat),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_sel(cfg_sel),
      .cfg_a(cfg_a), .cfg_b(cfg_b), .out_valid(out_valid), .out_score(out_score)
   );

   always #5 clk = ~clk;

   int m_sel [NT][NPT];
   int m_a   [NT][NPT];
   int m_b   [NT][NPT];

   int          n_checks = 0;
   int          n_fail   = 0;
   int unsigned cyc      = 0;
   bit          done     = 0;
   logic [33:0] exp_q [$];
   int unsigned exp_cyc [$];

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [33:0] model(input logic [255:0] v);
      longint acc = 0;
      for (int t = 0; t < NT; t++) begin
         int n = 0;
         int x;
         longint p;
         int lv;
         for (int l = 0; l < D; l++) begin
            x = v[32*m_sel[t][n] +: 32];
            if (x < m_a[t][n]) n = 2*n + 1;
            else n = 2*n + 2;
         end
         x  = v[32*m_sel[t][n] +: 32];
         p  = longint'(m_a[t][n]) * longint'(x);
         p  = p >>> 16;
         lv = int'(p) + m_b[t][n];
         acc += longint'(lv);
      end
      return acc[33:0];
   endfunction

   function automatic logic [255:0] rand_sample();
      logic [255:0] v;
      for (int f = 0; f < NF; f++) begin
         int r = int'($urandom % 4);
         int x;
         int tt = int'($urandom % NT);
         int nn = int'($urandom % 7);
         if (r < 2) x = int'($urandom % 2201) - 1100;
         else if (r == 2) x = m_a[tt][nn];
         else x = m_a[tt][nn] + (($urandom % 2) == 0 ? 1 : -1);
         v[32*f +: 32] = x;
      end
      return v;
   endfunction

   // one write per cycle; commit mirrors the write into the model
   task automatic wr(input int t, input int n, input int sel, input int a, input int b, input bit commit);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 6'(t*NPT + n); cfg_sel = 3'(sel); cfg_a = a; cfg_b = b;
      if (commit && t < NT && n < NPT) begin
         m_sel[t][n] = sel; m_a[t][n] = a; m_b[t][n] = b;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive a sample in the current negedge slot
   task automatic put(input logic [255:0] v);
      in_valid = 1'b1;
      in_feat  = v;
      exp_q.push_back(model(v));
      exp_cyc.push_back(cyc);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic load_random();
      for (int t = 0; t < NT; t++) begin
         for (int n = 0; n < NPT; n++) begin
            if (n < 7) wr(t, n, int'($urandom % NF), int'($urandom % 2001) - 1000, 0, 1);
            else wr(t, n, int'($urandom % NF), int'($urandom), int'($urandom), 1);
         end
      end
   endtask

   task automatic set_leaves(input int w, input int o);
      for (int t = 0; t < NT; t++)
         for (int n = 7; n < NPT; n++)
            wr(t, n, n % NF, w, o, 1);
   endtask

   // output monitor
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 score without input", 1, 0);
         end else begin
            logic [33:0] e;
            int unsigned c;
            e = exp_q.pop_front();
            c = exp_cyc.pop_front();
            check(out_score == e, "R1/R2/R3/R4/R10 score",
                  longint'($signed(out_score)), longint'($signed(e)));
            check(cyc - c == LAT, "R5 latency", longint'(cyc - c), LAT);
         end
      end
   end

   // cycle counter and watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R5 watchdog: actual cycle %0d expected below %0d", cyc, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4242);
      rst = 1'b1; in_valid = 1'b0; in_feat = '0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_sel = '0; cfg_a = '0; cfg_b = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9 reset state out_valid", out_valid, 0);
      rst = 1'b0;

      load_random();
      // R8: out-of-range addresses must not touch any node
      for (int a = 60; a < 64; a++) wr(a / NPT, a % NPT, 5, 32'h7fff_ffff, 32'h7fff_ffff, 0);
      idle(2);

      // R6: back-to-back stream, R7: write while busy is dropped
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         put(rand_sample());
         if (i == 150) begin
            cfg_we = 1'b1; cfg_addr = 6'(1*NPT + 0); cfg_sel = 3'd0; cfg_a = 32'h7fff_ffff; cfg_b = '0;
         end else begin
            cfg_we = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
      idle(12);
      check(exp_q.size() == 0, "R6 every streamed sample scored", exp_q.size(), 0);

      // R7: write in the same cycle as an entering sample, pipe otherwise empty
      @(negedge clk);
      put(rand_sample());
      cfg_we = 1'b1; cfg_addr = 6'(2*NPT + 0); cfg_sel = 3'd1; cfg_a = 32'h8000_0000; cfg_b = '0;
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
      idle(12);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (($urandom % 2) == 0) put(rand_sample());
         else in_valid = 1'b0;
      end
      idle(12);
      check(exp_q.size() == 0, "R7 drain after dropped writes", exp_q.size(), 0);

      // R4: every term at the positive and at the negative 32-bit limit
      set_leaves(0, 32'h7fff_ffff);
      idle(2);
      @(negedge clk); put(rand_sample());
      check(model(rand_sample()) == 34'(64'sd8589934588), "R4 positive limit model", 0, 0);
      idle(12);
      set_leaves(0, 32'h8000_0000);
      idle(2);
      @(negedge clk); put(rand_sample());
      @(negedge clk); put(rand_sample());
      idle(12);
      // R3: product truncation with extreme weight and feature
      set_leaves(32'h7fff_ffff, 32'h0000_1234);
      idle(2);
      @(negedge clk); put({8{32'h7fff_ffff}});
      @(negedge clk); put({8{32'h8000_0000}});
      @(negedge clk); put({8{32'hffff_ffff}});
      idle(12);

      load_random();
      idle(2);

      // R9: reset mid-stream drops in-flight samples, keeps tables
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         put(rand_sample());
      end
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(posedge clk); #1;
      exp_q.delete(); exp_cyc.delete();
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R9 out_valid low after reset", out_valid, 0);
      end
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         put(rand_sample());
      end
      idle(12);

      // R5: gapped random traffic
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (($urandom % 10) < 6) put(rand_sample());
         else in_valid = 1'b0;
      end
      idle(12);
      check(exp_q.size() == 0, "R5 all scores delivered in order", exp_q.size(), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule